// File: doc/BRIEF.md
# Real-Time Alarm Timer

This block keeps a free-running 64-bit time count and a 64-bit alarm threshold, and drives a level interrupt toward the core whenever the count has reached the threshold. The count advances by one on each pulse of a tick enable. That pulse comes from a slow real-time reference, nominally 32768 Hz, and is already synchronized to the bus clock.

Software reaches both 64-bit registers over a 32-bit register bus as pairs of words: the low word at a base offset and the high word at base+4. The block never snapshots or freezes the count. A carry from the low word into the high word can therefore fall between two reads, and software finds it by reading the high word again. The interrupt is compared against whatever threshold is stored at that moment, so a threshold written half at a time can briefly raise an interrupt that software did not intend.

The bus is plain strobes, not a stream. Every access is accepted in the cycle its strobe is high and cannot be stalled. The block returns exactly one ready pulse one cycle later, so no back-pressure exists on either side.

Top module: `rt_alarm_timer`

## Requirements
- R1: After reset the count is 0, the threshold is all ones, the interrupt output is 0 and ready is 0.
- R2: With no count write in the same cycle, each cycle with tick_en high adds one to the full 64-bit count. The carry propagates into the high word, and all ones rolls over to 0. With tick_en low the count holds.
- R3: irq_timer is high exactly while the stored count, taken as an unsigned number, is greater than or equal to the stored threshold. Equality counts. irq_timer responds in the cycle after the edge that changed either register, so it drops in the cycle after a write lifts the threshold above the count.
- R4: These byte offsets in the 16-bit window are decoded, each with bits [1:0] equal to 0: threshold low 0x4000, threshold high 0x4004, count low 0xBFF8, count high 0xBFFC. Any other address, including misaligned ones, is unmapped.
- R5: On a write, bus_be bit i enables write data bits [8i+7:8i] of the addressed word. Disabled bytes keep their old value.
- R6: A count write wins over a tick in the same cycle. The written bytes take the write data, and the rest of the count keeps its current value without an increment.
- R7: Reading one half of the count does not latch or freeze the other half. A tick between a high-word read and a low-word read shows up in the values returned.
- R8: The interrupt is evaluated against the threshold as stored after each single half write, even when the other half is not yet updated.
- R9: A read of an unmapped address returns 0. A write to an unmapped address changes no register.
- R10: bus_ready is high for exactly one cycle, the cycle after each read or write strobe. bus_rdata carries the addressed word as it stood before that edge while bus_ready is high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Synchronized real-time tick, one cycle per count step |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 16 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for a write |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle access completion |
| irq_timer | output | 1 | Timer interrupt level |

## Verification
Register updates from a write or a tick land on the clock edge that samples the strobe. The interrupt output is combinational from the stored registers, so it shows the new state in that same following cycle. Read data and ready are registered and appear one cycle after the strobe. The bench drives every input on the falling edge and samples one falling edge after the strobe or tick, which is the first point at which each result is due. Ready is checked again one cycle later to confirm it has dropped.

// File: rtl/rtat_pkg.sv
package rtat_pkg;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned HALF_W = REG_W / 2;
  localparam int unsigned NBYTES = HALF_W / 8;

  typedef logic [REG_W-1:0]  reg64_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [NBYTES-1:0] be_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_CNT_LO,
    SEL_CNT_HI
  } sel_e;

  // Replace the enabled bytes of one half of a 64-bit value.
  function automatic reg64_t put_half(reg64_t old, logic hi, half_t wd, be_t be);
    reg64_t r;
    r = old;
    for (int b = 0; b < int'(NBYTES); b++) begin
      if (be[b]) begin
        if (hi) r[HALF_W + 8*b +: 8] = wd[8*b +: 8];
        else    r[8*b +: 8]          = wd[8*b +: 8];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rtat_regif.sv
module rtat_regif
  import rtat_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CMP_OFS = 'h4000,
  parameter int unsigned CNT_OFS = 'hBFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  reg64_t            cnt_val,
  input  reg64_t            cmp_val,
  output logic              cnt_we,
  output logic              cmp_we,
  output logic              half_hi,
  output half_t             bus_rdata,
  output logic              bus_ready
);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(CMP_OFS);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(CMP_OFS + 4);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(CNT_OFS);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(CNT_OFS + 4);

  sel_e  sel;
  half_t rd_word;

  always_comb begin
    unique case (bus_addr)
      A_CMP_LO: sel = SEL_CMP_LO;
      A_CMP_HI: sel = SEL_CMP_HI;
      A_CNT_LO: sel = SEL_CNT_LO;
      A_CNT_HI: sel = SEL_CNT_HI;
      default:  sel = SEL_NONE;
    endcase
  end

  assign cnt_we  = bus_wr && (sel == SEL_CNT_LO || sel == SEL_CNT_HI);
  assign cmp_we  = bus_wr && (sel == SEL_CMP_LO || sel == SEL_CMP_HI);
  assign half_hi = (sel == SEL_CNT_HI) || (sel == SEL_CMP_HI);

  always_comb begin
    unique case (sel)
      SEL_CMP_LO: rd_word = cmp_val[HALF_W-1:0];
      SEL_CMP_HI: rd_word = cmp_val[REG_W-1:HALF_W];
      SEL_CNT_LO: rd_word = cnt_val[HALF_W-1:0];
      SEL_CNT_HI: rd_word = cnt_val[REG_W-1:HALF_W];
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_rd || bus_wr;
      bus_rdata <= bus_rd ? rd_word : '0;
    end
  end

  assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> bus_ready);
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> !bus_ready && bus_rdata == '0);
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0);
  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_we && cmp_we));
endmodule

// File: rtl/rtat_counter.sv
module rtat_counter
  import rtat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_en,
  input  logic   we,
  input  logic   hi,
  input  half_t  wdata,
  input  be_t    be,
  output reg64_t cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (we)      cnt_q <= put_half(cnt_q, hi, wdata, be);
    else if (tick_en) cnt_q <= cnt_q + 64'd1;
  end

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && tick_en) |=> cnt_q == $past(cnt_q) + 64'd1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !tick_en) |=> $stable(cnt_q));
  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && tick_en && !hi && be == '1) |=>
      cnt_q[HALF_W-1:0] == $past(wdata) && cnt_q[REG_W-1:HALF_W] == $past(cnt_q[REG_W-1:HALF_W]));
endmodule

// File: rtl/rtat_compare.sv
module rtat_compare
  import rtat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we,
  input  logic   hi,
  input  half_t  wdata,
  input  be_t    be,
  input  reg64_t cnt,
  output reg64_t cmp_q,
  output logic   irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmp_q <= '1;
    else if (we) cmp_q <= put_half(cmp_q, hi, wdata, be);
  end

  assign irq = (cnt >= cmp_q);

  assert_cmp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cmp_q));
  assert_cmp_other_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hi) |=> cmp_q[REG_W-1:HALF_W] == $past(cmp_q[REG_W-1:HALF_W]));
endmodule

// File: rtl/rt_alarm_timer.sv
module rt_alarm_timer
  import rtat_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CMP_OFS = 'h4000,
  parameter int unsigned CNT_OFS = 'hBFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              irq_timer
);
  reg64_t cnt_q, cmp_q;
  logic   cnt_we, cmp_we, half_hi;

  rtat_regif #(.ADDR_W(ADDR_W), .CMP_OFS(CMP_OFS), .CNT_OFS(CNT_OFS)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .cnt_val(cnt_q), .cmp_val(cmp_q), .cnt_we(cnt_we), .cmp_we(cmp_we),
    .half_hi(half_hi), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  rtat_counter u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .we(cnt_we), .hi(half_hi),
    .wdata(bus_wdata), .be(bus_be), .cnt_q(cnt_q)
  );

  rtat_compare u_compare (
    .clk(clk), .rst_n(rst_n), .we(cmp_we), .hi(half_hi), .wdata(bus_wdata),
    .be(bus_be), .cnt(cnt_q), .cmp_q(cmp_q), .irq(irq_timer)
  );

  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_timer) |-> (cnt_q != $past(cnt_q)) || (cmp_q != $past(cmp_q)));
  assert_irq_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_we && !cmp_we) |=> $stable(irq_timer));
endmodule

// File: tb/rt_alarm_timer_tb.sv
module rt_alarm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, irq_timer;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rt_alarm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq_timer(irq_timer)
  );

  localparam int NV = 15;
  localparam logic        V_RD  [NV] = '{1,1,1,1,0,1,0,1,0,1,0,1,1,1,1};
  localparam logic [15:0] V_ADR [NV] = '{16'hBFF8,16'hBFFC,16'h4000,16'h4004,16'hBFF8,16'hBFF8,
                                         16'hBFFC,16'hBFFC,16'h4000,16'h4000,16'h0100,16'h0100,
                                         16'hBFF8,16'h4002,16'h4008};
  localparam logic [31:0] V_DAT [NV] = '{0,0,0,0,32'h12345678,0,32'hDEADBEAB,0,32'hAABBCCDD,0,
                                         32'h5,0,0,0,0};
  localparam logic [3:0]  V_BE  [NV] = '{0,0,0,0,4'hF,0,4'h1,0,4'h6,0,4'hF,0,0,0,0};
  localparam logic [31:0] V_EXP [NV] = '{32'h0,32'h0,32'hFFFFFFFF,32'hFFFFFFFF,0,32'h12345678,0,
                                         32'h000000AB,0,32'hFFBBCCFF,0,32'h0,32'h12345678,32'h0,32'h0};
  localparam string       V_TAG [NV] = '{"R1","R1","R1","R1","R5","R4","R5","R5","R5","R5",
                                         "R9","R9","R9","R4","R9"};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [31:0] d, logic [3:0] be, logic tk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be; tick_en = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    chk("R10 write ready", {31'd0, bus_ready}, 32'd1);
  endtask

  task automatic bus_read(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R10 read ready", {31'd0, bus_ready}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic tick1();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq_timer}, 32'd0);
    chk("R1 ready after reset", {31'd0, bus_ready}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (V_RD[i]) begin
        bus_read(V_ADR[i], r);
        chk(V_TAG[i], r, V_EXP[i]);
      end else begin
        bus_write(V_ADR[i], V_DAT[i], V_BE[i], 1'b0);
      end
    end
    @(negedge clk);
    chk("R10 ready drops", {31'd0, bus_ready}, 32'd0);
    chk("R10 rdata idle", bus_rdata, 32'd0);

    // R2 carry across halves
    bus_write(16'hBFF8, 32'hFFFFFFFE, 4'hF, 1'b0);
    bus_write(16'hBFFC, 32'h0, 4'hF, 1'b0);
    tick1(); tick1();
    bus_read(16'hBFF8, r); chk("R2 carry low", r, 32'h0);
    bus_read(16'hBFFC, r); chk("R2 carry high", r, 32'h1);

    // R7 carry between two reads is visible
    bus_write(16'hBFF8, 32'hFFFFFFFF, 4'hF, 1'b0);
    bus_write(16'hBFFC, 32'h0, 4'hF, 1'b0);
    bus_read(16'hBFFC, r); chk("R7 high before", r, 32'h0);
    tick1();
    bus_read(16'hBFF8, r); chk("R7 low after tick", r, 32'h0);
    bus_read(16'hBFFC, r); chk("R7 high reread", r, 32'h1);

    // R6 write beats tick
    bus_write(16'hBFF8, 32'h00000010, 4'hF, 1'b1);
    bus_read(16'hBFF8, r); chk("R6 written low", r, 32'h10);
    bus_read(16'hBFFC, r); chk("R6 high untouched", r, 32'h1);

    // R2 rollover
    bus_write(16'hBFF8, 32'hFFFFFFFF, 4'hF, 1'b0);
    bus_write(16'hBFFC, 32'hFFFFFFFF, 4'hF, 1'b0);
    tick1();
    bus_read(16'hBFF8, r); chk("R2 rollover low", r, 32'h0);
    bus_read(16'hBFFC, r); chk("R2 rollover high", r, 32'h0);

    // R3 / R8 compare behaviour
    bus_write(16'h4000, 32'h0, 4'hF, 1'b0);
    bus_write(16'h4004, 32'h2, 4'hF, 1'b0);
    bus_write(16'hBFF8, 32'h00000010, 4'hF, 1'b0);
    bus_write(16'hBFFC, 32'h1, 4'hF, 1'b0);
    chk("R3 below threshold", {31'd0, irq_timer}, 32'd0);
    bus_write(16'h4004, 32'h1, 4'hF, 1'b0);
    chk("R8 half-written fires", {31'd0, irq_timer}, 32'd1);
    bus_write(16'h4000, 32'hFFFFFFF0, 4'hF, 1'b0);
    chk("R3 drops after write", {31'd0, irq_timer}, 32'd0);
    bus_write(16'hBFF8, 32'hFFFFFFEF, 4'hF, 1'b0);
    chk("R3 one below", {31'd0, irq_timer}, 32'd0);
    tick1();
    chk("R3 equal fires", {31'd0, irq_timer}, 32'd1);
    tick1();
    chk("R3 above holds", {31'd0, irq_timer}, 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule